// File: doc/BRIEF.md
# Four-Channel Capture and Merge FIFO

This block takes 10-bit words from up to four front-end chip channels and merges them into one tagged output stream. Each channel has its own clock-crossing queue. The queue is filled in a 20 MHz capture clock domain and emptied in a 25 MHz drain clock domain, and the drain domain feeds a network transmitter. The drain rate is above the capture rate so that a single active channel can keep a 100 Mb/s link busy.

A small scheduler in the drain domain picks the next queue to read. It serves the queues that hold data and are enabled, taking them in circular order, one word at a time. The chosen word leaves on a valid/ready port with the channel number placed above the data. Capture does not start until the front end reports that its initialization has finished. A per-channel disable bit removes a channel from both capture and draining, so single-chip operation is done by disabling the other three channels. A queue that is full drops any further words and raises a sticky flag for that channel. Both reset inputs clear every pointer and flag. They are pulsed at the end of each data-taking run or when the host asks for a reset.

Top module: `fe_capture_merge`

## Requirements
- R1: After both resets (active low, synchronous to their own clocks), out_valid is 0 and ovf_flags is 0. Words that were queued before the reset are never delivered.
- R2: While init_done is 0, input words are not captured. Words presented after init_done rises are captured.
- R3: Every word captured on channel c is delivered exactly once, in the order it arrived. out_data[11:10] holds c and out_data[9:0] holds the captured word.
- R4: After a grant to channel c, the next grant goes to the first channel after c, in increasing order with wrap-around, that is enabled and has data. After reset the search starts at channel 0.
- R5: A channel whose chan_mask bit is 1 captures nothing. Its input words never reach the output, and it never raises its overflow flag.
- R6: A channel whose chan_mask bit is 1 is never read. Words it already holds stay queued and are delivered in order once the bit returns to 0.
- R7: Each queue holds DEPTH words. A word offered to a full queue is dropped and sets that channel's bit in ovf_flags. The bit stays set until reset, and the words already stored are unchanged.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Capture clock (20 MHz nominal) |
| wrst_n | input | 1 | Active-low synchronous reset, capture domain |
| init_done | input | 1 | Front-end initialization finished; enables capture |
| in_valid | input | NUM_CH | Per-channel word strobe |
| in_data | input | NUM_CH*DATA_W | Per-channel words, channel c at bits [c*DATA_W +: DATA_W] |
| chan_mask | input | NUM_CH | 1 disables the channel for capture and draining (quasi-static) |
| ovf_flags | output | NUM_CH | Sticky per-channel overflow flags, capture domain |
| rclk | input | 1 | Drain clock (25 MHz nominal) |
| rrst_n | input | 1 | Active-low synchronous reset, drain domain |
| out_ready | input | 1 | Downstream accepts the output word |
| out_valid | output | 1 | Output word present |
| out_data | output | CH_W+DATA_W | Channel number above the captured word |

## Verification
A table of bursts loads the four queues with equal, unequal and empty counts while the output is held stalled. The merged stream is then drained, with out_ready either steady or alternating. Equal counts show the circular grant order. Unequal and empty counts show that drained queues are skipped without changing the order of the rest. Disable patterns, including the single-channel case, show that disabled inputs are discarded. Directed runs cover the following: words offered before initialization, disabling a channel that still holds data and then enabling it again, overfilling one queue by a few words so that the count of kept words and the flag can be checked, and a reset that must throw away queued data.

// File: rtl/fcm_pkg.sv
`timescale 1ns/1ps
// Shared defaults for the capture-and-merge block.
// Assumes: nothing; constants only.
package fcm_pkg;
    localparam int FCM_DEF_CHANNELS    = 4;
    localparam int FCM_DEF_WORD_W      = 10;
    localparam int FCM_DEF_DEPTH       = 512;
    localparam int FCM_SYNC_STAGES     = 2;
endpackage

// File: rtl/fcm_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer for a Gray-coded bus.
// Assumes: input changes by at most one bit per source clock.
module fcm_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the bus through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fcm_afifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with Gray pointers and a sticky drop flag.
// Assumes: AW >= 2; both resets asserted together; reads are show-ahead.
module fcm_afifo #(
    parameter int DW     = 10,
    parameter int AW     = 9,
    parameter int STAGES = 2
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ovf,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, wbin_nx, rbin, rgray, rbin_nx;
    logic [PW-1:0] rgray_w, wgray_r;
    logic          wr_full, wr_ok, rd_ok;

    fcm_sync #(.W(PW), .STAGES(STAGES)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
    fcm_sync #(.W(PW), .STAGES(STAGES)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

    assign wbin_nx = wbin + PW'(1);
    assign rbin_nx = rbin + PW'(1);
    assign wr_full = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    assign wr_ok   = wr_req & ~wr_full;
    assign rd_empty = (rgray == wgray_r);
    assign rd_ok   = rd_req & ~rd_empty;
    assign rd_data = mem[rbin[AW-1:0]];

    // Advance the write pointer and latch drops on a full queue.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            wr_ovf <= 1'b0;
        end else begin
            if (wr_ok) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (wr_req && wr_full) wr_ovf <= 1'b1;
        end
    end

    // Store accepted words.
    always_ff @(posedge wclk) begin
        if (wr_ok) mem[wbin[AW-1:0]] <= wr_data;
    end

    // Advance the read pointer on each pop.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_ok) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end
endmodule

// File: rtl/fcm_rr_arb.sv
`timescale 1ns/1ps
// Circular-order arbiter; search starts after the last granted index.
// Assumes: N >= 2; the grant is taken only when adv is high.
module fcm_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 adv,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 gnt_any
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] last;
    logic [IW-1:0] cand;

    // Find the first requester after the last grant.
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = last;
        cand    = last;
        for (int i = 1; i <= N; i++) begin
            cand = IW'((int'(last) + i) % N);
            if (!gnt_any && req[cand]) begin
                gnt_any = 1'b1;
                gnt_idx = cand;
            end
        end
    end

    // Remember the last channel served.
    always_ff @(posedge clk) begin
        if (!rst_n)                 last <= IW'(N - 1);
        else if (adv && gnt_any)    last <= gnt_idx;
    end
endmodule

// File: rtl/fe_capture_merge.sv
`timescale 1ns/1ps
// Per-channel clock-crossing capture queues merged into one tagged stream.
// Assumes: chan_mask is quasi-static with respect to both clocks;
// init_done is synchronous to wclk.
module fe_capture_merge
    import fcm_pkg::*;
#(
    parameter int NUM_CH = FCM_DEF_CHANNELS,
    parameter int DATA_W = FCM_DEF_WORD_W,
    parameter int DEPTH  = FCM_DEF_DEPTH,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int OUT_W = CH_W + DATA_W
) (
    input  logic                     wclk,
    input  logic                     wrst_n,
    input  logic                     init_done,
    input  logic [NUM_CH-1:0]        in_valid,
    input  logic [NUM_CH*DATA_W-1:0] in_data,
    input  logic [NUM_CH-1:0]        chan_mask,
    output logic [NUM_CH-1:0]        ovf_flags,
    input  logic                     rclk,
    input  logic                     rrst_n,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_data
);
    localparam int AW = $clog2(DEPTH);

    logic [NUM_CH-1:0] push, pop, empty, req;
    logic [DATA_W-1:0] rd_word [NUM_CH];
    logic [CH_W-1:0]   gnt_idx;
    logic              gnt_any, take;

    assign take = ~out_valid | out_ready;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign push[c] = init_done & in_valid[c] & ~chan_mask[c];
        assign req[c]  = ~empty[c] & ~chan_mask[c];
        assign pop[c]  = take & gnt_any & (gnt_idx == CH_W'(c));

        fcm_afifo #(.DW(DATA_W), .AW(AW), .STAGES(FCM_SYNC_STAGES)) u_q (
            .wclk    (wclk),
            .wrst_n  (wrst_n),
            .wr_req  (push[c]),
            .wr_data (in_data[c*DATA_W +: DATA_W]),
            .wr_ovf  (ovf_flags[c]),
            .rclk    (rclk),
            .rrst_n  (rrst_n),
            .rd_req  (pop[c]),
            .rd_data (rd_word[c]),
            .rd_empty(empty[c])
        );
    end

    fcm_rr_arb #(.N(NUM_CH)) u_arb (
        .clk    (rclk),
        .rst_n  (rrst_n),
        .req    (req),
        .adv    (take),
        .gnt_idx(gnt_idx),
        .gnt_any(gnt_any)
    );

    // Output register: load the granted word whenever the slot frees.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= gnt_any;
            if (gnt_any) out_data <= {gnt_idx, rd_word[gnt_idx]};
        end
    end
endmodule

// File: rtl/fcm_checker.sv
`timescale 1ns/1ps
// Protocol checks for fe_capture_merge, attached by bind.
// Assumes: resets held for several cycles at start.
module fcm_checker #(
    parameter int NUM_CH = 4,
    parameter int OUT_W  = 12
) (
    input logic              wclk,
    input logic              wrst_n,
    input logic              init_done,
    input logic [NUM_CH-1:0] in_valid,
    input logic [NUM_CH-1:0] chan_mask,
    input logic [NUM_CH-1:0] ovf_flags,
    input logic              rclk,
    input logic              rrst_n,
    input logic              out_ready,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_data
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0] mask_q;

    // Mask value seen by the drain logic at the previous edge.
    always_ff @(posedge rclk) mask_q <= chan_mask;

    // R1: reset empties the output slot.
    a_r1_reset_idle: assert property (@(posedge rclk)
        !rrst_n |=> !out_valid);

    // R8: a stalled word is held unchanged.
    a_r8_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: a newly loaded word never comes from a disabled channel.
    a_r6_masked_read: assert property (@(posedge rclk) disable iff (!rrst_n)
        (out_valid && (!$past(out_valid) || $past(out_ready)))
        |-> !mask_q[out_data[OUT_W-1 -: CH_W]]);

    // R7: overflow flags never clear outside reset.
    a_r7_sticky: assert property (@(posedge wclk) disable iff (!wrst_n)
        ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    // R5 and R2: a flag rises only on an enabled write after init.
    a_r5_ovf_cause: assert property (@(posedge wclk) disable iff (!wrst_n)
        ((ovf_flags & ~$past(ovf_flags)) != '0)
        |-> ($past(init_done) &&
             ((ovf_flags & ~$past(ovf_flags) & ~$past(in_valid & ~chan_mask)) == '0)));
endmodule

bind fe_capture_merge fcm_checker #(.NUM_CH(NUM_CH), .OUT_W(OUT_W)) u_chk (
    .wclk     (wclk),
    .wrst_n   (wrst_n),
    .init_done(init_done),
    .in_valid (in_valid),
    .chan_mask(chan_mask),
    .ovf_flags(ovf_flags),
    .rclk     (rclk),
    .rrst_n   (rrst_n),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/fe_capture_merge_test.sv
`timescale 1ns/1ps
module fe_capture_merge_test;
    localparam int NCH   = 4;
    localparam int DW    = 10;
    localparam int DEPTH = 512;

    logic              wclk = 1'b0, rclk = 1'b0;
    logic              wrst_n = 1'b0, rrst_n = 1'b0;
    logic              init_done = 1'b0;
    logic [NCH-1:0]    in_valid = '0;
    logic [NCH*DW-1:0] in_data = '0;
    logic [NCH-1:0]    chan_mask = '0;
    logic [NCH-1:0]    ovf_flags;
    logic              out_ready = 1'b0;
    logic              out_valid;
    logic [11:0]       out_data;

    int  errs = 0, checks = 0;
    bit  finished = 1'b0;
    logic [11:0] got[$];
    logic [11:0] exp_q[$];

    // {ready toggles, mask[3:0], count ch0, ch1, ch2, ch3}
    localparam logic [36:0] VEC [5] = '{
        {1'b0, 4'b0000, 8'd3, 8'd3, 8'd3, 8'd3},
        {1'b1, 4'b1110, 8'd5, 8'd5, 8'd5, 8'd5},
        {1'b0, 4'b0000, 8'd1, 8'd4, 8'd0, 8'd2},
        {1'b1, 4'b0101, 8'd2, 8'd3, 8'd4, 8'd5},
        {1'b0, 4'b0000, 8'd0, 8'd0, 8'd6, 8'd0}
    };

    always #2.5   rclk = ~rclk;
    always #3.125 wclk = ~wclk;

    fe_capture_merge uut (
        .wclk(wclk), .wrst_n(wrst_n), .init_done(init_done), .in_valid(in_valid),
        .in_data(in_data), .chan_mask(chan_mask), .ovf_flags(ovf_flags),
        .rclk(rclk), .rrst_n(rrst_n), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge rclk);
        wrst_n = 1'b0; rrst_n = 1'b0; init_done = 1'b0;
        in_valid = '0; out_ready = 1'b0; chan_mask = '0;
        repeat (8) @(negedge rclk);
        rrst_n = 1'b1;
        @(negedge wclk);
        wrst_n = 1'b1;
        repeat (3) @(negedge rclk);
    endtask

    // Offer cnt[c] words on each channel; word = {c, seq[7:0]}.
    task automatic write_burst(input int cnt [4]);
        int rem [4];
        int seq [4];
        bit any;
        for (int c = 0; c < NCH; c++) begin rem[c] = cnt[c]; seq[c] = 0; end
        any = 1'b1;
        while (any) begin
            @(negedge wclk);
            any = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                in_valid[c] = (rem[c] > 0);
                in_data[c*DW +: DW] = {2'(c), 8'(seq[c])};
                if (rem[c] > 0) begin rem[c]--; seq[c]++; any = 1'b1; end
            end
        end
        @(negedge wclk);
        in_valid = '0;
    endtask

    task automatic collect(input int cycles, input bit toggle);
        for (int k = 0; k < cycles; k++) begin
            @(negedge rclk);
            out_ready = toggle ? k[0] : 1'b1;
            if (out_valid && out_ready) got.push_back(out_data);
        end
        @(negedge rclk);
        out_ready = 1'b0;
    endtask

    // Expected merge order from the circular-grant rule, start after ch3.
    task automatic build_expected(input logic [3:0] mask, input int cnt [4]);
        int rem [4];
        int seq [4];
        int ptr;
        bit hit;
        exp_q.delete();
        for (int c = 0; c < NCH; c++) begin
            rem[c] = mask[c] ? 0 : cnt[c];
            seq[c] = 0;
        end
        ptr = 3;
        hit = 1'b1;
        while (hit) begin
            hit = 1'b0;
            for (int i = 1; i <= NCH; i++) begin
                int c;
                c = (ptr + i) % NCH;
                if (!hit && rem[c] > 0) begin
                    exp_q.push_back({2'(c), 2'(c), 8'(seq[c])});
                    seq[c]++; rem[c]--; ptr = c; hit = 1'b1;
                end
            end
        end
    endtask

    initial begin
        int cnt [4];
        logic [36:0] vec;
        logic [11:0] held;
        int bad;

        // R1: reset state
        do_reset();
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(ovf_flags == '0, "R1", "ovf_flags after reset", int'(ovf_flags), 0);

        // Table walk: R3 R4 R5 under several fill and mask patterns
        for (int v = 0; v < 5; v++) begin
            vec = VEC[v];
            cnt[0] = int'(vec[31:24]); cnt[1] = int'(vec[23:16]);
            cnt[2] = int'(vec[15:8]);  cnt[3] = int'(vec[7:0]);
            do_reset();
            chan_mask = vec[35:32];
            init_done = 1'b1;
            write_burst(cnt);
            repeat (20) @(negedge rclk);
            build_expected(vec[35:32], cnt);
            got.delete();
            collect(exp_q.size() * 2 + 40, vec[36]);
            check(got.size() == exp_q.size(), "R3", $sformatf("word count vec%0d", v),
                  got.size(), exp_q.size());
            for (int i = 0; i < exp_q.size() && i < got.size(); i++)
                check(got[i] == exp_q[i], "R4", $sformatf("vec%0d word %0d", v, i),
                      int'(got[i]), int'(exp_q[i]));
            check(ovf_flags == '0, "R5", $sformatf("no overflow vec%0d", v),
                  int'(ovf_flags), 0);
        end

        // R2: words before init_done are ignored, later ones are captured
        do_reset();
        cnt = '{3, 3, 3, 3};
        write_burst(cnt);
        repeat (20) @(negedge rclk);
        got.delete();
        collect(40, 1'b0);
        check(got.size() == 0, "R2", "words before init", got.size(), 0);
        init_done = 1'b1;
        cnt = '{0, 0, 0, 1};
        write_burst(cnt);
        repeat (20) @(negedge rclk);
        got.delete();
        collect(40, 1'b0);
        check(got.size() == 1, "R2", "words after init", got.size(), 1);
        if (got.size() > 0)
            check(got[0] == 12'hF00, "R2", "word after init", int'(got[0]), 'hF00);

        // R6 and R8: disable a channel that holds data, then enable it again
        do_reset();
        init_done = 1'b1;
        cnt = '{2, 2, 2, 2};
        write_burst(cnt);
        repeat (20) @(negedge rclk);
        held = out_data;
        check(out_valid && out_data == 12'h000, "R4", "first grant is ch0",
              int'(out_data), 'h000);
        repeat (8) @(negedge rclk);
        check(out_valid && out_data == held, "R8", "stalled word held",
              int'(out_data), int'(held));
        chan_mask = 4'b0100;
        got.delete();
        collect(60, 1'b0);
        exp_q = '{12'h000, 12'h500, 12'hF00, 12'h001, 12'h501, 12'hF01};
        check(got.size() == 6, "R6", "words with ch2 disabled", got.size(), 6);
        for (int i = 0; i < 6 && i < got.size(); i++)
            check(got[i] == exp_q[i], "R6", $sformatf("masked order %0d", i),
                  int'(got[i]), int'(exp_q[i]));
        chan_mask = 4'b0000;
        got.delete();
        collect(40, 1'b0);
        check(got.size() == 2, "R6", "held ch2 words after enable", got.size(), 2);
        if (got.size() == 2) begin
            check(got[0] == 12'hA00, "R6", "ch2 word 0", int'(got[0]), 'hA00);
            check(got[1] == 12'hA01, "R6", "ch2 word 1", int'(got[1]), 'hA01);
        end

        // R7: overfill ch1 by four words with output stalled
        do_reset();
        init_done = 1'b1;
        cnt = '{0, DEPTH + 5, 0, 0};
        write_burst(cnt);
        repeat (10) @(negedge wclk);
        check(ovf_flags == 4'b0010, "R7", "flag set on drop", int'(ovf_flags), 'h2);
        got.delete();
        collect(DEPTH + 80, 1'b0);
        check(got.size() == DEPTH + 1, "R7", "kept words", got.size(), DEPTH + 1);
        bad = 0;
        for (int i = 0; i < got.size(); i++)
            if (got[i] != {2'd1, 2'd1, 8'(i)}) bad++;
        check(bad == 0, "R7", "stored words unchanged", bad, 0);
        check(ovf_flags == 4'b0010, "R7", "flag sticky after drain", int'(ovf_flags), 'h2);

        // R1: reset clears the flag and discards queued words
        init_done = 1'b1;
        cnt = '{2, 2, 2, 2};
        write_burst(cnt);
        do_reset();
        check(ovf_flags == '0, "R1", "flag cleared by reset", int'(ovf_flags), 0);
        got.delete();
        collect(40, 1'b0);
        check(got.size() == 0, "R1", "queued words discarded", got.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule